// File: doc/BRIEF.md
# Reset and Power-Mode Sequencer

This block decides, every oscillator period, whether the CPU core and the peripheral set of a small 8-bit microcontroller get a clock, whether the oscillator stays enabled, and whether the internal reset line is driven. It filters the raw reset pin so that only a pulse lasting at least two machine cycles is accepted. It also carries out the two software-requested low-power modes. In idle, the CPU stops and the peripherals keep running. In power-down, the oscillator itself stops.

The core raises one-cycle request strobes for idle or power-down when software sets the matching control bits. The interrupt controller supplies a vector of pending, enabled interrupt flags. Any pending flag ends idle. In power-down the flags are ignored, and only the reset pin wakes the part. On that wake-up the oscillator restarts and is given a settling interval, set at an input, before the reset sequence releases the core. If a reset ends idle, the CPU may run briefly before the qualified reset takes over. Internal RAM writes are blocked over that gap, so on-chip RAM survives the reset, while the SFRs are reloaded by the internal reset.

Top module: `rstpm_ctrl`

## Requirements
- R1: While `por_n` is low the outputs are {cpu_clk_en,per_clk_en,osc_en,int_rst,ram_wr_blk} = 11111. One clock edge after `por_n` rises with `rst_pin` low, the block is running (11100).
- R2: A high level on `rst_pin` seen on 23 or fewer consecutive edges never asserts `int_rst`. A high level held for 37 edges asserts it, and it has not asserted after 24 edges. `int_rst` drops on the first edge that samples `rst_pin` low.
- R3: An `idle_req` strobe while running turns `cpu_clk_en` off and leaves `per_clk_en` and `osc_en` on.
- R4: In idle, any set bit of `irq_pend` brings the block back to running on the next edge.
- R5: In idle, `rst_pin` high restarts the CPU clock on the next edge with `ram_wr_blk` high and `int_rst` low. `int_rst` follows once the pin qualifies, within 37 edges.
- R6: A `pd_req` strobe while running turns off `cpu_clk_en`, `per_clk_en` and `osc_en`.
- R7: `pd_req` and `idle_req` in the same cycle select power-down.
- R8: In power-down, interrupts and further requests have no effect; the outputs stay 00000.
- R9: In power-down, `rst_pin` high drives outputs 00111 for `settle_cnt` edges (a value of 0 counts as 1). The outputs then become 11111 until `rst_pin` is low.
- R10: `ram_wr_blk` is high whenever `int_rst` is high, and low while running or idle.
- R11: A reset pulse that ends idle but drops before it qualifies returns the block to running with `ram_wr_blk` low.
- R12: Interrupts while running change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin | input | 1 | Raw external reset pin, active high |
| idle_req | input | 1 | One-cycle idle request from the core |
| pd_req | input | 1 | One-cycle power-down request from the core |
| irq_pend | input | NIRQ (4) | Pending enabled interrupt flags |
| settle_cnt | input | SW (16) | Oscillator settling length after power-down exit |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| int_rst | output | 1 | Internal reset to core and SFRs |
| ram_wr_blk | output | 1 | Internal RAM write inhibit |

## Verification
All five outputs are a direct decode of the registered mode state. A wrong mode therefore shows at the ports one edge after the stimulus that caused it, as a mismatched 5-bit output pattern. The reset-pin qualifier is the exception, because its error only shows as `int_rst` rising too early or too late. It is pinned down by bracketing pulses just below and above the acceptance window. The settling counter is checked by counting the edges with the 00111 pattern for two different `settle_cnt` values, including zero.

// File: rtl/rstpm_pkg.sv
package rstpm_pkg;

  typedef enum logic [2:0] {
    PM_RST    = 3'd0,
    PM_RUN    = 3'd1,
    PM_IDLE   = 3'd2,
    PM_WAKE   = 3'd3,
    PM_PDOWN  = 3'd4,
    PM_SETTLE = 3'd5
  } pm_state_e;

  typedef struct packed {
    logic cpu;
    logic per;
    logic osc;
    logic rst;
    logic blk;
  } pm_out_t;

  function automatic pm_out_t pm_decode(pm_state_e s);
    pm_out_t o;
    case (s)
      PM_RUN:    o = '{cpu:1'b1, per:1'b1, osc:1'b1, rst:1'b0, blk:1'b0};
      PM_IDLE:   o = '{cpu:1'b0, per:1'b1, osc:1'b1, rst:1'b0, blk:1'b0};
      PM_WAKE:   o = '{cpu:1'b1, per:1'b1, osc:1'b1, rst:1'b0, blk:1'b1};
      PM_PDOWN:  o = '{cpu:1'b0, per:1'b0, osc:1'b0, rst:1'b0, blk:1'b0};
      PM_SETTLE: o = '{cpu:1'b0, per:1'b0, osc:1'b1, rst:1'b1, blk:1'b1};
      default:   o = '{cpu:1'b1, per:1'b1, osc:1'b1, rst:1'b1, blk:1'b1};
    endcase
    return o;
  endfunction

  // Settling ends on the edge where the count of elapsed cycles reaches the limit.
  // A zero limit behaves like one.
  function automatic logic settle_reached(logic [31:0] elapsed, logic [31:0] limit);
    return (elapsed + 32'd1) >= limit;
  endfunction

  // The pin qualifies once enough machine-cycle boundaries were seen while it stayed high.
  function automatic logic qual_reached(logic [31:0] ticks, logic [31:0] need);
    return ticks >= need;
  endfunction

endpackage

// File: rtl/rstpm_mcdiv.sv
module rstpm_mcdiv #(
  parameter int MC_LEN = 12
) (
  input  logic clk,
  input  logic por_n,
  output logic mc_tick
);
  localparam int DW = (MC_LEN > 2) ? $clog2(MC_LEN) : 1;
  localparam logic [DW-1:0] LAST = DW'(MC_LEN - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign mc_tick = (div_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!por_n)
    mc_tick |=> !mc_tick); // R2

endmodule

// File: rtl/rstpm_qual.sv
module rstpm_qual #(
  parameter int QUAL_TICKS = 3
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin,
  input  logic mc_tick,
  input  logic hold_clr,
  output logic qual
);
  import rstpm_pkg::*;
  localparam int CW = $clog2(QUAL_TICKS + 1);

  logic [CW-1:0] tick_q;

  assign qual = qual_reached(32'(tick_q), 32'(QUAL_TICKS));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                   tick_q <= '0;
    else if (!rst_pin || hold_clr) tick_q <= '0;
    else if (mc_tick && !qual)    tick_q <= tick_q + 1'b1;
  end

  AST_QUAL_NEEDS_PIN: assert property (@(posedge clk) disable iff (!por_n)
    qual |-> $past(rst_pin)); // R2

  AST_QUAL_ON_TICK: assert property (@(posedge clk) disable iff (!por_n)
    $rose(qual) |-> $past(mc_tick)); // R2

endmodule

// File: rtl/rstpm_settle.sv
module rstpm_settle #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          active,
  input  logic [SW-1:0] limit,
  output logic          done
);
  import rstpm_pkg::*;

  logic [SW-1:0] cnt_q;

  assign done = active && settle_reached(32'(cnt_q), 32'(limit));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else if (!done)   cnt_q <= cnt_q + 1'b1;
  end

  AST_SETTLE_FROM_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    $rose(active) |-> (cnt_q == '0)); // R9

endmodule

// File: rtl/rstpm_fsm.sv
module rstpm_fsm (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 rst_pin,
  input  logic                 idle_req,
  input  logic                 pd_req,
  input  logic                 irq_any,
  input  logic                 qual,
  input  logic                 settle_done,
  output rstpm_pkg::pm_state_e st_q
);
  import rstpm_pkg::*;

  pm_state_e st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      PM_RST:    if (!rst_pin) st_d = PM_RUN;
      PM_RUN: begin
        if (qual)          st_d = PM_RST;
        else if (pd_req)   st_d = PM_PDOWN;
        else if (idle_req) st_d = PM_IDLE;
      end
      PM_IDLE: begin
        if (rst_pin)      st_d = PM_WAKE;
        else if (irq_any) st_d = PM_RUN;
      end
      PM_WAKE: begin
        if (qual)          st_d = PM_RST;
        else if (!rst_pin) st_d = PM_RUN;
      end
      PM_PDOWN:  if (rst_pin) st_d = PM_SETTLE;
      PM_SETTLE: if (settle_done) st_d = PM_RST;
      default:   st_d = PM_RST;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) st_q <= PM_RST;
    else        st_q <= st_d;
  end

  AST_PD_NO_IRQ_WAKE: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == PM_PDOWN && !rst_pin) |=> (st_q == PM_PDOWN)); // R8

  AST_IDLE_IRQ_EXIT: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == PM_IDLE && !rst_pin && irq_any) |=> (st_q == PM_RUN)); // R4

  AST_PD_OVER_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == PM_RUN && !qual && pd_req) |=> (st_q == PM_PDOWN)); // R7

  AST_IDLE_RST_GAP: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == PM_IDLE && rst_pin) |=> (st_q == PM_WAKE)); // R5

  AST_SETTLE_TO_RST: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == PM_SETTLE && settle_done) |=> (st_q == PM_RST)); // R9

  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == PM_RST && !rst_pin) |=> (st_q == PM_RUN)); // R2

endmodule

// File: rtl/rstpm_ctrl.sv
module rstpm_ctrl #(
  parameter int NIRQ       = 4,
  parameter int SW         = 16,
  parameter int MC_LEN     = 12,
  parameter int QUAL_TICKS = 3
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_pin,
  input  logic            idle_req,
  input  logic            pd_req,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [SW-1:0]   settle_cnt,
  output logic            cpu_clk_en,
  output logic            per_clk_en,
  output logic            osc_en,
  output logic            int_rst,
  output logic            ram_wr_blk
);
  import rstpm_pkg::*;

  logic      mc_tick;
  logic      qual;
  logic      settle_done;
  logic      osc_off;
  logic      in_settle;
  logic      irq_any;
  pm_state_e st_q;
  pm_out_t   outs;

  assign irq_any   = |irq_pend;
  assign in_settle = (st_q == PM_SETTLE);
  assign osc_off   = (st_q == PM_PDOWN) || in_settle;

  rstpm_mcdiv #(.MC_LEN(MC_LEN)) u_div (
    .clk(clk), .por_n(por_n), .mc_tick(mc_tick)
  );

  rstpm_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .mc_tick(mc_tick),
    .hold_clr(osc_off), .qual(qual)
  );

  rstpm_settle #(.SW(SW)) u_settle (
    .clk(clk), .por_n(por_n), .active(in_settle), .limit(settle_cnt),
    .done(settle_done)
  );

  rstpm_fsm u_fsm (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .idle_req(idle_req),
    .pd_req(pd_req), .irq_any(irq_any), .qual(qual),
    .settle_done(settle_done), .st_q(st_q)
  );

  assign outs       = pm_decode(st_q);
  assign cpu_clk_en = outs.cpu;
  assign per_clk_en = outs.per;
  assign osc_en     = outs.osc;
  assign int_rst    = outs.rst;
  assign ram_wr_blk = outs.blk;

  AST_BLK_DURING_RST: assert property (@(posedge clk) disable iff (!por_n)
    int_rst |-> ram_wr_blk); // R10

  AST_RST_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(int_rst) |-> $past(rst_pin)); // R2

endmodule

// File: tb/rstpm_ctrl_tb.sv
module rstpm_ctrl_tb;

  logic        clk = 1'b0;
  logic        por_n;
  logic        rst_pin;
  logic        idle_req;
  logic        pd_req;
  logic [3:0]  irq_pend;
  logic [15:0] settle_cnt;
  logic        cpu_clk_en, per_clk_en, osc_en, int_rst, ram_wr_blk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rstpm_ctrl u_dut (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .idle_req(idle_req),
    .pd_req(pd_req), .irq_pend(irq_pend), .settle_cnt(settle_cnt),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .int_rst(int_rst), .ram_wr_blk(ram_wr_blk)
  );

  function automatic logic [4:0] outs();
    return {cpu_clk_en, per_clk_en, osc_en, int_rst, ram_wr_blk};
  endfunction

  task automatic chk(input string req, input logic [4:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, outs(), exp, $time);
    end
  endtask

  // {req[15:12], pin, idle, pd, irq[8:5], expected cpu/per/osc/rst/blk}
  localparam logic [15:0] VEC [0:10] = '{
    {4'd10, 1'b0, 1'b0, 1'b0, 4'b0000, 5'b11100}, // R10 running, no block
    {4'd12, 1'b0, 1'b0, 1'b0, 4'b0101, 5'b11100}, // R12 irq while running
    {4'd3,  1'b0, 1'b1, 1'b0, 4'b0000, 5'b01100}, // R3 idle entry
    {4'd3,  1'b0, 1'b0, 1'b0, 4'b0000, 5'b01100}, // R3 idle holds
    {4'd4,  1'b0, 1'b0, 1'b0, 4'b1000, 5'b11100}, // R4 high irq bit wakes
    {4'd3,  1'b0, 1'b1, 1'b0, 4'b0000, 5'b01100}, // R3 idle again
    {4'd4,  1'b0, 1'b0, 1'b0, 4'b0001, 5'b11100}, // R4 low irq bit wakes
    {4'd7,  1'b0, 1'b1, 1'b1, 4'b0000, 5'b00000}, // R7 both requests, R6 pd
    {4'd8,  1'b0, 1'b0, 1'b0, 4'b1111, 5'b00000}, // R8 irq ignored
    {4'd8,  1'b0, 1'b1, 1'b0, 4'b0000, 5'b00000}, // R8 idle_req ignored
    {4'd6,  1'b0, 1'b0, 1'b0, 4'b0000, 5'b00000}  // R6 stays down
  };

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_pin = 1'b0; idle_req = 1'b0; pd_req = 1'b0;
    irq_pend = '0; settle_cnt = 16'd5;
    repeat (3) @(negedge clk);
    chk("R1 reset state", 5'b11111);
    por_n = 1'b1;
    @(negedge clk);
    chk("R1 run after por", 5'b11100);

    for (int i = 0; i < 11; i++) begin
      rst_pin  = VEC[i][11];
      idle_req = VEC[i][10];
      pd_req   = VEC[i][9];
      irq_pend = VEC[i][8:5];
      @(negedge clk);
      chk($sformatf("R%0d vector %0d", VEC[i][15:12], i), VEC[i][4:0]);
    end
    idle_req = 1'b0; pd_req = 1'b0; irq_pend = '0;

    // R9 exit power-down with settle length 5
    rst_pin = 1'b1;
    @(negedge clk);
    chk("R9 settle start", 5'b00111);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 settling", 5'b00111);
    end
    @(negedge clk);
    chk("R9 settle over", 5'b11111);
    rst_pin = 1'b0;
    @(negedge clk);
    chk("R2 release after settle", 5'b11100);

    // R9 zero settle length behaves as one
    pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
    chk("R6 power-down", 5'b00000);
    settle_cnt = 16'd0;
    rst_pin = 1'b1;
    @(negedge clk);
    chk("R9 zero settle first", 5'b00111);
    @(negedge clk);
    chk("R9 zero settle done", 5'b11111);
    rst_pin = 1'b0;
    @(negedge clk);
    chk("R2 release", 5'b11100);

    // R2 short pulse of 23 edges is filtered
    begin
      logic seen = 1'b0;
      rst_pin = 1'b1;
      for (int k = 0; k < 23; k++) begin
        @(negedge clk);
        if (int_rst) seen = 1'b1;
      end
      rst_pin = 1'b0;
      checks++;
      if (seen) begin
        errors++;
        $display("FAIL R2 short pulse: int_rst 1 expected 0");
      end
      @(negedge clk);
      chk("R2 after short pulse", 5'b11100);
    end

    // R2 long pulse qualifies
    begin
      logic early = 1'b0;
      rst_pin = 1'b1;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (int_rst) early = 1'b1;
      end
      checks++;
      if (early) begin
        errors++;
        $display("FAIL R2 early reset: int_rst 1 expected 0 within 24 edges");
      end
      repeat (13) @(negedge clk);
      chk("R2 R10 qualified reset", 5'b11111);
      rst_pin = 1'b0;
      @(negedge clk);
      chk("R2 reset release", 5'b11100);
    end

    // R5 reset ends idle
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    chk("R3 idle", 5'b01100);
    rst_pin = 1'b1;
    @(negedge clk);
    chk("R5 gap with RAM block", 5'b11101);
    repeat (36) @(negedge clk);
    chk("R5 reset takes over", 5'b11111);
    rst_pin = 1'b0;
    @(negedge clk);
    chk("R5 release", 5'b11100);

    // R11 unqualified pulse out of idle
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    rst_pin = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 in gap", 5'b11101);
    rst_pin = 1'b0;
    @(negedge clk);
    chk("R11 back to run", 5'b11100);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule